// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block converts one command request into the command-latch and address-latch bus cycles that a NAND device with 512-byte pages expects. A request carries an opcode, an optional column and an optional row (page) address. Once the block takes the request, it holds chip enable low. It then clocks out each byte with a write-enable pulse. Command bytes go out with the command latch high, and address bytes go out with the address latch high. When the opcode class calls for it, the block finally hands control to an external wait unit and waits for that unit to report completion.

Small-page parts split each page into a lower half, an upper half and a spare area. A program-setup request therefore starts with a pointer command that selects the region named by the column. The column itself is always sent as a single address byte. Two configuration inputs adapt the block to the device. One selects a 16-bit data bus, which halves byte columns into word columns. The other adds a third row byte. A third input states whether a ready/busy pin exists. This input decides how the block waits after reset and after read-type commands.

Top module: `nsq_sp_sequencer`

## Requirements
- R1: During and after reset, with no request pending, nand_ce_n=1, nand_cle=0, nand_ale=0, nand_we_n=1, wait_req=0 and req_ready=1.
- R2: Each byte takes two clocks. In the first clock nand_we_n=0 and in the second nand_we_n=1, and nand_dq, nand_cle and nand_ale hold for both clocks. The first byte is the pointer byte when there is one; otherwise it is the opcode itself. nand_ce_n stays 0 from the first byte until the request finishes, including any wait.
- R3: For opcode 0x80, a pointer command byte goes out before 0x80. The pointer is 0x50 when the column is 512 or more, 0x01 when the column is 256 to 511, and 0x00 when the column is below 256 or no column is given.
- R4: When a column is given, exactly one address byte carries it. For opcode 0x80 with a column of 512 or more, 512 is first subtracted. On a 16-bit bus the value is then shifted right by one, except for opcodes 0x90, 0xEE and 0xEF. The byte sent is bits 7:0 of the result.
- R5: When a row is given, it follows the column as row bits 7:0 and then bits 15:8. Bits 23:16 follow as a third byte only when cfg_row3=1.
- R6: nand_cle and nand_ale are never both high. Between two consecutive bytes of different latch type there is exactly one clock with both latches low and nand_we_n=1. Between bytes of the same type there is no such clock.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF never raise wait_req. req_ready returns in the clock after the last byte's second clock.
- R8: When cfg_has_rb=1, opcode 0xFF is followed by a wait of kind 1 (pin). When cfg_has_rb=0, it is followed by a wait of kind 0 (fixed delay). After that wait comes one command byte 0x70 with no gap clock, and then a wait of kind 2 (status poll).
- R9: Opcodes 0x00, 0x01 and 0x50 given with neither a column nor a row finish without a wait.
- R10: Every other opcode is followed by one wait: kind 1 when cfg_has_rb=1, and kind 0 otherwise.
- R11: req_ready is 0 from the clock after acceptance until the request ends. A request presented while busy is ignored and produces no bus cycle. The busy time is two clocks per byte, plus one per gap clock, plus the wait time.
- R12: While wait_req is 1, wait_kind holds. wait_req drops in the clock after wait_done is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_opcode | input | 8 | Command opcode |
| req_has_col | input | 1 | Column address supplied |
| req_col | input | 10 | Column address in bytes (0 to 527) |
| req_has_row | input | 1 | Row address supplied |
| req_row | input | 24 | Row (page) address |
| cfg_bus16 | input | 1 | Device uses a 16-bit data bus |
| cfg_row3 | input | 1 | Send a third row byte |
| cfg_has_rb | input | 1 | A ready/busy pin is available |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_dq | output | 8 | Command or address byte |
| wait_req | output | 1 | Wait unit requested |
| wait_kind | output | 2 | 0 fixed delay, 1 ready pin, 2 status poll |
| wait_done | input | 1 | Wait unit finished |

## Verification
The first byte's write-enable low phase appears in the clock after the accepting edge. After that, each byte takes exactly two clocks, each latch-type change adds one gap clock, and each wait lasts until the clock after wait_done is taken. The bench samples every output on the falling edge, one sample per clock. From the first sample after acceptance to the first sample with req_ready high, it logs each byte, each gap clock and each wait request. It then compares the byte values, the gap positions, the wait kinds and the busy-clock total with values computed from the request. The responder in the bench always raises wait_done on the second clock of a wait, which makes every wait last exactly two clocks and keeps the busy-clock total exact.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

   localparam logic [7:0] OP_RD_LO       = 8'h00;
   localparam logic [7:0] OP_RD_HI       = 8'h01;
   localparam logic [7:0] OP_RD_SPARE    = 8'h50;
   localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
   localparam logic [7:0] OP_PROG_GO     = 8'h10;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
   localparam logic [7:0] OP_STATUS      = 8'h70;
   localparam logic [7:0] OP_READ_ID     = 8'h90;
   localparam logic [7:0] OP_FEAT_GET    = 8'hEE;
   localparam logic [7:0] OP_FEAT_SET    = 8'hEF;
   localparam logic [7:0] OP_RESET       = 8'hFF;

   typedef enum logic [1:0] {
      WK_DELAY  = 2'd0,
      WK_PIN    = 2'd1,
      WK_STATUS = 2'd2
   } wait_kind_e;

   typedef enum logic [1:0] {
      PLAN_NONE,
      PLAN_PIN,
      PLAN_DELAY,
      PLAN_DELAY_STATUS
   } wait_plan_e;

   typedef struct packed {
      logic       is_addr;
      logic [7:0] val;
   } bus_slot_t;

   // Opcodes whose column is always given in bytes, even on a 16-bit bus
   function automatic logic op_is_narrow(input logic [7:0] op);
      return (op == OP_READ_ID) || (op == OP_FEAT_GET) || (op == OP_FEAT_SET);
   endfunction

endpackage

// File: rtl/nsq_frame_builder.sv
module nsq_frame_builder
   import nsq_pkg::*;
#(
   parameter int PAGE_BYTES = 512,
   parameter int COL_W      = 10,
   parameter int ROW_W      = 24,
   parameter int MAX_SLOTS  = 6,
   parameter int CNT_W      = 3
) (
   input  logic [7:0]                  op,
   input  logic                        has_col,
   input  logic [COL_W-1:0]            col,
   input  logic                        has_row,
   input  logic [ROW_W-1:0]            row,
   input  logic                        bus16,
   input  logic                        row3,
   output bus_slot_t [MAX_SLOTS-1:0]   slots,
   output logic [CNT_W-1:0]            count
);

   localparam int HALF_BYTES = PAGE_BYTES / 2;

   if (PAGE_BYTES < 2 || (1 << COL_W) <= PAGE_BYTES) begin : g_bad_col
      $error("nsq_frame_builder: column width cannot hold page size");
   end
   if (ROW_W < 16 || ROW_W > 24) begin : g_bad_row
      $error("nsq_frame_builder: row width must be 16 to 24");
   end

   logic [7:0] row_hi;
   logic       row_third;

   if (ROW_W > 16) begin : g_row3
      assign row_hi    = 8'(row[ROW_W-1:16]);
      assign row_third = row3;
   end else begin : g_row2
      assign row_hi    = 8'h00;
      assign row_third = 1'b0;
   end

   logic [CNT_W-1:0] n;
   logic [COL_W-1:0] col_region;
   logic [7:0]       ptr;
   logic [7:0]       col_byte;

   always_comb begin
      ptr        = OP_RD_LO;
      col_region = col;
      if (has_col) begin
         if (col >= COL_W'(PAGE_BYTES)) begin
            ptr = OP_RD_SPARE;
            if (op == OP_PROG_SETUP) col_region = col - COL_W'(PAGE_BYTES);
         end else if (col >= COL_W'(HALF_BYTES)) begin
            ptr = OP_RD_HI;
         end
      end
      col_byte = (bus16 && !op_is_narrow(op)) ? 8'(col_region >> 1) : 8'(col_region);

      slots = '0;
      n     = '0;
      if (op == OP_PROG_SETUP) begin
         slots[n] = {1'b0, ptr};
         n        = n + CNT_W'(1);
      end
      slots[n] = {1'b0, op};
      n        = n + CNT_W'(1);
      if (has_col) begin
         slots[n] = {1'b1, col_byte};
         n        = n + CNT_W'(1);
      end
      if (has_row) begin
         slots[n] = {1'b1, row[7:0]};
         n        = n + CNT_W'(1);
         slots[n] = {1'b1, row[15:8]};
         n        = n + CNT_W'(1);
         if (row_third) begin
            slots[n] = {1'b1, row_hi};
            n        = n + CNT_W'(1);
         end
      end
      count = n;
   end

endmodule

// File: rtl/nsq_wait_classifier.sv
module nsq_wait_classifier
   import nsq_pkg::*;
(
   input  logic [7:0]  op,
   input  logic        has_col,
   input  logic        has_row,
   input  logic        has_pin,
   output wait_plan_e  plan
);

   wait_plan_e busy_wait;

   assign busy_wait = has_pin ? PLAN_PIN : PLAN_DELAY;

   always_comb begin
      case (op)
         OP_PROG_GO, OP_ERASE_SETUP, OP_ERASE_GO, OP_PROG_SETUP,
         OP_STATUS, OP_READ_ID, OP_FEAT_SET:
            plan = PLAN_NONE;
         OP_RESET:
            plan = has_pin ? PLAN_PIN : PLAN_DELAY_STATUS;
         OP_RD_LO, OP_RD_HI, OP_RD_SPARE:
            plan = (!has_col && !has_row) ? PLAN_NONE : busy_wait;
         default:
            plan = busy_wait;
      endcase
   end

endmodule

// File: rtl/nsq_sp_sequencer.sv
module nsq_sp_sequencer
   import nsq_pkg::*;
#(
   parameter int PAGE_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int ROW_W       = 24,
   localparam int COL_W      = $clog2(PAGE_BYTES + SPARE_BYTES),
   localparam int MAX_SLOTS  = (ROW_W > 16) ? 6 : 5,
   localparam int CNT_W      = $clog2(MAX_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [7:0]        req_opcode,
   input  logic              req_has_col,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_has_row,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              cfg_bus16,
   input  logic              cfg_row3,
   input  logic              cfg_has_rb,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic [7:0]        nand_dq,
   output logic              wait_req,
   output logic [1:0]        wait_kind,
   input  logic              wait_done
);

   if (SPARE_BYTES < 1) begin : g_bad_spare
      $error("nsq_sp_sequencer: spare area must be present");
   end

   typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_WAIT} seq_state_e;

   bus_slot_t [MAX_SLOTS-1:0] slots_d, slots_q;
   logic [CNT_W-1:0]          cnt_d, cnt_q, idx_q, idx_nxt;
   wait_plan_e                plan_d, plan_q;
   wait_kind_e                kind_q;
   seq_state_e                state_q;
   logic                      stat_q;
   bus_slot_t                 cur;

   nsq_frame_builder #(
      .PAGE_BYTES (PAGE_BYTES),
      .COL_W      (COL_W),
      .ROW_W      (ROW_W),
      .MAX_SLOTS  (MAX_SLOTS),
      .CNT_W      (CNT_W)
   ) i_frame (
      .op      (req_opcode),
      .has_col (req_has_col),
      .col     (req_col),
      .has_row (req_has_row),
      .row     (req_row),
      .bus16   (cfg_bus16),
      .row3    (cfg_row3),
      .slots   (slots_d),
      .count   (cnt_d)
   );

   nsq_wait_classifier i_class (
      .op      (req_opcode),
      .has_col (req_has_col),
      .has_row (req_has_row),
      .has_pin (cfg_has_rb),
      .plan    (plan_d)
   );

   assign idx_nxt = idx_q + CNT_W'(1);
   assign cur     = slots_q[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slots_q <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         plan_q  <= PLAN_NONE;
         kind_q  <= WK_DELAY;
         stat_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               slots_q <= slots_d;
               cnt_q   <= cnt_d;
               plan_q  <= plan_d;
               idx_q   <= '0;
               stat_q  <= 1'b0;
               state_q <= ST_LOW;
            end
            ST_LOW: state_q <= ST_HIGH;
            ST_GAP: state_q <= ST_LOW;
            ST_HIGH: begin
               if (idx_nxt < cnt_q) begin
                  idx_q   <= idx_nxt;
                  state_q <= (slots_q[idx_nxt].is_addr != cur.is_addr) ? ST_GAP : ST_LOW;
               end else if (stat_q) begin
                  kind_q  <= WK_STATUS;
                  state_q <= ST_WAIT;
               end else begin
                  case (plan_q)
                     PLAN_NONE: state_q <= ST_IDLE;
                     PLAN_PIN: begin
                        kind_q  <= WK_PIN;
                        state_q <= ST_WAIT;
                     end
                     default: begin
                        kind_q  <= WK_DELAY;
                        state_q <= ST_WAIT;
                     end
                  endcase
               end
            end
            ST_WAIT: if (wait_done) begin
               if (plan_q == PLAN_DELAY_STATUS && !stat_q) begin
                  stat_q     <= 1'b1;
                  slots_q[0] <= {1'b0, OP_STATUS};
                  cnt_q      <= CNT_W'(1);
                  idx_q      <= '0;
                  state_q    <= ST_LOW;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic on_bus;
   assign on_bus    = (state_q == ST_LOW) || (state_q == ST_HIGH);
   assign req_ready = (state_q == ST_IDLE);
   assign nand_ce_n = (state_q == ST_IDLE);
   assign nand_cle  = on_bus && !cur.is_addr;
   assign nand_ale  = on_bus && cur.is_addr;
   assign nand_we_n = (state_q != ST_LOW);
   assign nand_dq   = on_bus ? cur.val : 8'h00;
   assign wait_req  = (state_q == ST_WAIT);
   assign wait_kind = kind_q;

   // R2
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |=> nand_we_n);
   // R2
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |=> ($stable(nand_dq) && $stable(nand_cle) && $stable(nand_ale)));
   // R6
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   // R6
   cle_to_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_cle |=> !nand_ale);
   // R6
   ale_to_cle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_ale |=> !nand_cle);
   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !nand_ce_n));
   // R12
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !wait_done) |=> (wait_req && $stable(wait_kind)));
   // R12
   wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && wait_done) |=> !wait_req);

endmodule

// File: tb/test_nsq_sp_sequencer.sv
module test_nsq_sp_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_opcode = 8'h00;
   logic        req_has_col = 1'b0;
   logic [9:0]  req_col = '0;
   logic        req_has_row = 1'b0;
   logic [23:0] req_row = '0;
   logic        cfg_bus16 = 1'b0;
   logic        cfg_row3 = 1'b0;
   logic        cfg_has_rb = 1'b0;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n;
   logic [7:0]  nand_dq;
   logic        wait_req;
   logic [1:0]  wait_kind;
   logic        wait_done = 1'b0;

   always #5 clk = ~clk;

   nsq_sp_sequencer i_nsq_sp_sequencer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_opcode(req_opcode), .req_has_col(req_has_col), .req_col(req_col),
      .req_has_row(req_has_row), .req_row(req_row), .cfg_bus16(cfg_bus16),
      .cfg_row3(cfg_row3), .cfg_has_rb(cfg_has_rb), .nand_ce_n(nand_ce_n),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_dq(nand_dq), .wait_req(wait_req), .wait_kind(wait_kind),
      .wait_done(wait_done)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   int    ex_val[16];
   bit    ex_addr[16];
   int    ex_gap[16];
   string ex_tag[16];
   int    ex_n;
   int    exw[4];
   int    exwn;
   string wtag;

   int lg_val[16];
   bit lg_addr[16];
   bit lg_cle[16];
   int lg_gap[16];
   int lg_n;
   int wk[4];
   int wn;

   task automatic push(input int v, input bit a, input string t, input bit after_wait);
      ex_val[ex_n]  = v;
      ex_addr[ex_n] = a;
      ex_tag[ex_n]  = t;
      ex_gap[ex_n]  = (ex_n > 0 && !after_wait && a != ex_addr[ex_n-1]) ? 1 : 0;
      ex_n++;
   endtask

   task automatic build_exp(input int op, input bit hc, input int col, input bit hr,
                            input int row, input bit b16, input bit r3, input bit pin);
      int c;
      bit nowait, rd;
      ex_n = 0;
      exwn = 0;
      if (op == 'h80)
         push(hc ? (col >= 512 ? 'h50 : (col >= 256 ? 'h01 : 'h00)) : 'h00, 1'b0, "R3", 1'b0);
      push(op, 1'b0, "R2", 1'b0);
      if (hc) begin
         c = col;
         if (op == 'h80 && c >= 512) c = c - 512;
         if (b16 && !(op == 'h90 || op == 'hEE || op == 'hEF)) c = c >> 1;
         push(c & 255, 1'b1, "R4", 1'b0);
      end
      if (hr) begin
         push(row & 255, 1'b1, "R5", 1'b0);
         push((row >> 8) & 255, 1'b1, "R5", 1'b0);
         if (r3) push((row >> 16) & 255, 1'b1, "R5", 1'b0);
      end
      nowait = (op == 'h10 || op == 'h60 || op == 'hD0 || op == 'h80 ||
                op == 'h70 || op == 'h90 || op == 'hEF);
      rd = (op == 'h00 || op == 'h01 || op == 'h50);
      if (nowait) begin
         wtag = "R7";
      end else if (op == 'hFF) begin
         wtag = "R8";
         if (pin) begin
            exw[0] = 1; exwn = 1;
         end else begin
            exw[0] = 0; exw[1] = 2; exwn = 2;
            push('h70, 1'b0, "R8", 1'b1);
         end
      end else if (rd && !hc && !hr) begin
         wtag = "R9";
      end else begin
         wtag = "R10";
         exw[0] = pin ? 1 : 0; exwn = 1;
      end
   endtask

   task automatic run_req(input int op, input bit hc, input int col, input bit hr,
                          input int row, input int poke_at);
      int busy, gapc, guard, wcnt, exp_busy;
      bit prev_low, done, ce_bad;
      build_exp(op, hc, col, hr, row, cfg_bus16, cfg_row3, cfg_has_rb);
      @(negedge clk);
      req_opcode  = 8'(op);
      req_has_col = hc;
      req_col     = 10'(col);
      req_has_row = hr;
      req_row     = 24'(row);
      req_valid   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lg_n = 0; wn = 0; busy = 0; gapc = 0; guard = 0; wcnt = 0;
      prev_low = 1'b0; done = 1'b0; ce_bad = 1'b0;
      while (!done) begin
         wait_done = 1'b0;
         if (req_ready) begin
            done = 1'b1;
         end else begin
            busy++;
            req_valid = (busy == poke_at);
            if (busy == poke_at) req_opcode = 8'hFF;
            if (nand_ce_n) ce_bad = 1'b1;
            if (wait_req) begin
               if (wcnt == 0 && wn < 4) begin
                  wk[wn] = int'(wait_kind);
                  wn++;
               end
               wcnt++;
               if (wcnt == 2) begin
                  wait_done = 1'b1;
                  wcnt = 0;
               end
            end else if (!nand_we_n) begin
               if (lg_n < 16) begin
                  lg_val[lg_n]  = int'(nand_dq);
                  lg_addr[lg_n] = nand_ale;
                  lg_cle[lg_n]  = nand_cle;
                  lg_gap[lg_n]  = gapc;
                  lg_n++;
               end
               gapc = 0;
               prev_low = 1'b1;
            end else if (prev_low) begin
               prev_low = 1'b0;
               chk(lg_n > 0 && int'(nand_dq) == lg_val[lg_n-1] && nand_ale == lg_addr[lg_n-1]
                   && nand_cle == lg_cle[lg_n-1], "R2 byte hold", int'(nand_dq), lg_val[lg_n-1]);
            end else begin
               gapc++;
               chk(!nand_cle && !nand_ale, "R6 gap latches low", {nand_cle, nand_ale}, 0);
            end
            @(negedge clk);
            guard++;
            if (guard > 300) begin
               chk(1'b0, "R11 request never ended", guard, 0);
               done = 1'b1;
            end
         end
      end
      wait_done = 1'b0;
      req_valid = 1'b0;
      chk(!ce_bad, "R2 ce held low", ce_bad, 0);
      chk(lg_n == ex_n, "R2 byte count", lg_n, ex_n);
      for (int i = 0; i < ex_n && i < lg_n; i++) begin
         chk(lg_val[i] == ex_val[i] && lg_addr[i] == ex_addr[i] && lg_cle[i] != lg_addr[i],
             ex_tag[i], lg_val[i], ex_val[i]);
         chk(lg_gap[i] == ex_gap[i], "R6 gap", lg_gap[i], ex_gap[i]);
      end
      chk(wn == exwn, wtag, wn, exwn);
      for (int i = 0; i < exwn && i < wn; i++)
         chk(wk[i] == exw[i], wtag, wk[i], exw[i]);
      exp_busy = 2 * ex_n + 2 * exwn;
      for (int i = 0; i < ex_n; i++) exp_busy += ex_gap[i];
      chk(busy == exp_busy, (exwn == 0) ? "R7 busy clocks" : "R11 busy clocks", busy, exp_busy);
   endtask

   int ops[13] = '{'h00, 'h01, 'h50, 'h80, 'h10, 'h60, 'hD0, 'h70, 'h90, 'hEE, 'hEF, 'hFF, 'h30};
   int cols[6] = '{0, 255, 256, 511, 512, 527};

   initial begin
      int k;
      // R1: outputs while reset is held and right after release
      repeat (3) @(negedge clk);
      chk(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && !wait_req && req_ready,
          "R1 in reset", {nand_ce_n, nand_cle, nand_ale, nand_we_n, wait_req, req_ready}, 'b100101);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && !wait_req && req_ready,
          "R1 after reset", {nand_ce_n, nand_cle, nand_ale, nand_we_n, wait_req, req_ready}, 'b100101);

      // R11: a request presented while busy is dropped
      cfg_has_rb = 1'b0; cfg_bus16 = 1'b0; cfg_row3 = 1'b1;
      run_req('h80, 1'b1, 300, 1'b1, 'h123456, 3);
      repeat (4) begin
         @(negedge clk);
         chk(nand_ce_n && req_ready && nand_we_n, "R11 ignored request", nand_ce_n, 1);
      end

      // R3 R4 R5 R6 R7 R8 R9 R10: sweep of opcodes, columns and configurations
      k = 0;
      for (int cfg = 0; cfg < 8; cfg++) begin
         cfg_has_rb = cfg[0];
         cfg_bus16  = cfg[1];
         cfg_row3   = cfg[2];
         for (int oi = 0; oi < 13; oi++)
            for (int ci = 0; ci < 7; ci++)
               for (int hr = 0; hr < 2; hr++) begin
                  k++;
                  run_req(ops[oi], ci != 6, (ci == 6) ? 0 : cols[ci], hr[0],
                          (k * 'h3A5C7 + 'h12F0E1) & 'hFFFFFF, -1);
               end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule